// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the bus engine of an I2C master. Software steers it through a small control word of self-clearing command bits. Each command bit starts exactly one bus phase:

- a start condition
- a repeated start
- a stop condition
- the reception of one byte
- the transmission of a single acknowledge bit

A write to the transmit port starts sending one byte and then sampling the slave's answer.

SDA and SCL are open-drain lines. The block drives them only through pull-low enables (`sclOe`, `sdaOe`: 1 pulls the line low, 0 releases it). It reads the SDA level back on `sdaIn`. Each SCL low phase and each high phase lasts `divVal + 1` system clocks. The value of `divVal` is latched when an operation is accepted.

Nothing is queued. While any phase is running, command bits and transmit writes are refused. The caller waits for `busy` to fall, or for the one-cycle `done` pulse, before issuing the next step.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the control word reads 0, `busy`, `done` and `rxFull` are 0, and both lines are released (`sclOe` = `sdaOe` = 0).
- R2: A control write with only bit 0 set runs a start, one phase each: SCL and SDA released; then SDA low with SCL released; then both low.
- R3: Bit 1 alone runs a repeated start, one phase each: SCL low with SDA released; both released; SDA low with SCL released; both low.
- R4: Bit 2 alone runs a stop, one phase each: both low; SCL released with SDA low; both released. The lines stay released afterwards.
- R5: A transmit write while idle sends the byte MSB first, one SCL pulse per bit, and releases SDA for a ninth pulse. The SDA level sampled at the end of that ninth high phase goes to read bit 6: 1 means no acknowledge, 0 means acknowledge.
- R6: Bit 3 alone receives eight bits MSB first with SDA released, sampling at the end of each high phase. At the end the byte appears on `rxData` and `rxFull` rises. `rxFull` clears when the next operation is accepted.
- R7: Bit 4 alone sends one acknowledge pulse carrying the acknowledge-data value (read/write bit 5: 0 = ACK drives SDA low, 1 = NACK releases it). A bit 5 value written in the same word is used.
- R8: The command bit of the running phase reads back as 1 in bits 4..0 while the phase runs, and clears by itself when the phase ends. At most one command bit reads 1 at a time.
- R9: While `busy`, command bits and transmit writes are ignored. Bit 5 is still updated by every control write.
- R10: A control write with more than one of bits 4..0 set starts nothing.
- R11: Every phase lasts `divVal + 1` clocks. During byte and acknowledge phases, SDA changes only while SCL is low. The last SCL high of such a phase is followed by one low phase with SDA held.
- R12: `busy` is high exactly while a phase runs. `done` is a single-cycle pulse in the first idle cycle after each phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low synchronous reset |
| divVal | input | DIV_W | SCL half-period minus one, in clocks |
| ctlWe | input | 1 | control word write strobe |
| ctlWdata | input | 6 | bits 4..0 commands (start, repeated start, stop, receive, acknowledge), bit 5 acknowledge data |
| ctlRdata | output | 7 | bits 4..0 running command, bit 5 acknowledge data, bit 6 acknowledge status |
| txWe | input | 1 | transmit byte write strobe |
| txData | input | 8 | byte to transmit |
| rxData | output | 8 | last received byte |
| rxFull | output | 1 | a received byte is available |
| busy | output | 1 | a bus phase is running |
| done | output | 1 | one-cycle end-of-phase pulse |
| sclOe | output | 1 | pull SCL low when 1 |
| sdaOe | output | 1 | pull SDA low when 1 |
| sdaIn | input | 1 | sampled SDA line level |

## Verification
The assertions assume the following about the block's inputs:
- `sdaIn` reflects the wired-AND of the block's own pull-down and the slave's drive.
- The slave changes SDA only while SCL is low.
- `divVal` is non-zero whenever a byte or receive phase runs, so every low phase has time for the slave to change SDA.

The bench's slave model meets all three. It derives `sdaIn` from `sdaOe` and its own bit. It advances its bit index one clock after each SCL falling edge. It uses `divVal` of 1 or 3 for byte phases, and tries a zero divider only on start and stop.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 5;
  localparam int SHIFT_W = BYTE_W + 1;

  // command bit positions in the control word
  localparam int CB_START   = 0;
  localparam int CB_RESTART = 1;
  localparam int CB_STOP    = 2;
  localparam int CB_RX      = 3;
  localparam int CB_ACK     = 4;
  localparam int CB_ACKDATA = 5;
  localparam int CB_ACKSTAT = 6;
  localparam int CTL_RW     = CB_ACKSTAT + 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_START, OP_RESTART, OP_STOP, OP_RX, OP_ACK, OP_TX
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic opStart;
    logic loadTx;
    logic loadRx;
    logic loadAck;
    logic shiftIn;
    logic sclLow;
    logic sclRel;
    logic sdaLow;
    logic sdaRel;
    logic sdaBit;
    logic capRx;
    logic capAck;
  } dp_stb_t;
endpackage

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             ctlWe,
  input  logic [CMD_W-1:0] cmdField,
  input  logic             txWe,
  output dp_stb_t          stb,
  output op_e              curOp,
  output logic             busy,
  output logic             done,
  output logic             bitOp
);
  localparam int BITCNT_W = $clog2(SHIFT_W + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ST_A, S_ST_B, S_ST_C,
    S_RS_A, S_RS_B, S_RS_C, S_RS_D,
    S_SP_A, S_SP_B, S_SP_C,
    S_BIT_LO, S_BIT_HI, S_TAIL
  } state_e;

  state_e state, stateNxt;
  op_e op, newOp;
  logic [DIV_W-1:0] phaseCnt, divQ;
  logic [BITCNT_W-1:0] bitsLeft, bitsInit;
  logic cmdOne, accept, phaseEnd, isIdle;

  assign isIdle   = (state == S_IDLE);
  assign cmdOne   = (cmdField != '0) && ((cmdField & (cmdField - 1'b1)) == '0);
  assign phaseEnd = (phaseCnt == divQ);

  always_comb begin
    newOp = OP_NONE;
    if (ctlWe && cmdOne) begin
      if (cmdField[CB_START])        newOp = OP_START;
      else if (cmdField[CB_RESTART]) newOp = OP_RESTART;
      else if (cmdField[CB_STOP])    newOp = OP_STOP;
      else if (cmdField[CB_RX])      newOp = OP_RX;
      else                           newOp = OP_ACK;
    end else if (txWe) begin
      newOp = OP_TX;
    end
  end

  assign accept = isIdle && (newOp != OP_NONE);

  always_comb begin
    case (newOp)
      OP_TX:   bitsInit = BITCNT_W'(SHIFT_W - 1);
      OP_RX:   bitsInit = BITCNT_W'(BYTE_W - 1);
      default: bitsInit = '0;
    endcase
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    if (isIdle) begin
      if (accept) begin
        stb.opStart = 1'b1;
        case (newOp)
          OP_START:   begin stateNxt = S_ST_A; stb.sclRel = 1'b1; stb.sdaRel = 1'b1; end
          OP_RESTART: begin stateNxt = S_RS_A; stb.sclLow = 1'b1; stb.sdaRel = 1'b1; end
          OP_STOP:    begin stateNxt = S_SP_A; stb.sclLow = 1'b1; stb.sdaLow = 1'b1; end
          OP_TX:      begin stateNxt = S_BIT_LO; stb.loadTx  = 1'b1; stb.sclLow = 1'b1; stb.sdaBit = 1'b1; end
          OP_RX:      begin stateNxt = S_BIT_LO; stb.loadRx  = 1'b1; stb.sclLow = 1'b1; stb.sdaBit = 1'b1; end
          OP_ACK:     begin stateNxt = S_BIT_LO; stb.loadAck = 1'b1; stb.sclLow = 1'b1; stb.sdaBit = 1'b1; end
          default:    stateNxt = S_IDLE;
        endcase
      end
    end else if (phaseEnd) begin
      case (state)
        S_ST_A:   begin stateNxt = S_ST_B; stb.sdaLow = 1'b1; end
        S_ST_B:   begin stateNxt = S_ST_C; stb.sclLow = 1'b1; end
        S_RS_A:   begin stateNxt = S_RS_B; stb.sclRel = 1'b1; end
        S_RS_B:   begin stateNxt = S_RS_C; stb.sdaLow = 1'b1; end
        S_RS_C:   begin stateNxt = S_RS_D; stb.sclLow = 1'b1; end
        S_SP_A:   begin stateNxt = S_SP_B; stb.sclRel = 1'b1; end
        S_SP_B:   begin stateNxt = S_SP_C; stb.sdaRel = 1'b1; end
        S_BIT_LO: begin stateNxt = S_BIT_HI; stb.sclRel = 1'b1; end
        S_BIT_HI: begin
          stb.shiftIn = 1'b1;
          stb.sclLow  = 1'b1;
          if (bitsLeft == '0) begin
            stateNxt = S_TAIL;
          end else begin
            stateNxt   = S_BIT_LO;
            stb.sdaBit = 1'b1;
          end
        end
        S_TAIL: begin
          stateNxt   = S_IDLE;
          stb.capRx  = (op == OP_RX);
          stb.capAck = (op == OP_TX);
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      op       <= OP_NONE;
      phaseCnt <= '0;
      divQ     <= '0;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (isIdle) begin
        if (accept) begin
          state    <= stateNxt;
          op       <= newOp;
          phaseCnt <= '0;
          divQ     <= divVal;
          bitsLeft <= bitsInit;
        end
      end else if (phaseEnd) begin
        phaseCnt <= '0;
        state    <= stateNxt;
        if (state == S_BIT_HI && bitsLeft != '0) bitsLeft <= bitsLeft - 1'b1;
        if (stateNxt == S_IDLE) begin
          done <= 1'b1;
          op   <= OP_NONE;
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  assign busy  = !isIdle;
  assign curOp = op;
  assign bitOp = (op == OP_TX) || (op == OP_RX) || (op == OP_ACK);

  // R12: done lasts exactly one cycle and only once idle
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: the running operation cannot be replaced while busy
  assert_lockout_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(op));
  // R11: phase counter never passes the latched divider
  assert_phase_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phaseCnt <= divQ));
endmodule

// File: rtl/i2c_seq_dp.sv
module i2c_seq_dp
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_stb_t           stb,
  input  logic              ctlWe,
  input  logic              ackDataIn,
  input  logic [BYTE_W-1:0] txData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxFull,
  output logic              ackStat,
  output logic              ackData
);
  logic [SHIFT_W-1:0] shiftQ, loadVal, shiftNxt;
  logic ackNow, anyLoad;

  assign ackNow  = ctlWe ? ackDataIn : ackData;
  assign anyLoad = stb.loadTx || stb.loadRx || stb.loadAck;

  always_comb begin
    loadVal = {SHIFT_W{1'b1}};
    if (stb.loadTx)       loadVal = {txData, 1'b1};
    else if (stb.loadAck) loadVal = {ackNow, {BYTE_W{1'b1}}};
  end

  always_comb begin
    if (anyLoad)          shiftNxt = loadVal;
    else if (stb.shiftIn) shiftNxt = {shiftQ[SHIFT_W-2:0], sdaIn};
    else                  shiftNxt = shiftQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '1;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      rxData  <= '0;
      rxFull  <= 1'b0;
      ackStat <= 1'b0;
      ackData <= 1'b0;
    end else begin
      shiftQ <= shiftNxt;
      if (stb.sclLow)      sclOe <= 1'b1;
      else if (stb.sclRel) sclOe <= 1'b0;
      if (stb.sdaLow)      sdaOe <= 1'b1;
      else if (stb.sdaRel) sdaOe <= 1'b0;
      else if (stb.sdaBit) sdaOe <= ~shiftNxt[SHIFT_W-1];
      if (ctlWe) ackData <= ackDataIn;
      if (stb.capRx) begin
        rxData <= shiftQ[BYTE_W-1:0];
        rxFull <= 1'b1;
      end else if (stb.opStart) begin
        rxFull <= 1'b0;
      end
      if (stb.capAck) ackStat <= shiftQ[0];
    end
  end

  // R6: a new received byte is flagged only by a receive capture
  assert_rxfull_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(stb.capRx));
  // R11: SDA never moves while the controller releases SCL in the same cycle
  assert_no_sda_on_rise_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.sclRel && !stb.sdaLow && !stb.sdaRel) |-> $stable(sdaOe));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              ctlWe,
  input  logic [5:0]        ctlWdata,
  output logic [CTL_RW-1:0] ctlRdata,
  input  logic              txWe,
  input  logic [7:0]        txData,
  output logic [7:0]        rxData,
  output logic              rxFull,
  output logic              busy,
  output logic              done,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              sdaIn
);
  dp_stb_t stb;
  op_e curOp;
  logic bitOp, ackStat, ackData;
  logic [CMD_W-1:0] cmdBits;

  i2c_seq_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divVal(divVal), .ctlWe(ctlWe),
    .cmdField(ctlWdata[CMD_W-1:0]), .txWe(txWe), .stb(stb),
    .curOp(curOp), .busy(busy), .done(done), .bitOp(bitOp)
  );

  i2c_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlWe(ctlWe),
    .ackDataIn(ctlWdata[CB_ACKDATA]), .txData(txData), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .rxData(rxData), .rxFull(rxFull),
    .ackStat(ackStat), .ackData(ackData)
  );

  always_comb begin
    cmdBits = '0;
    case (curOp)
      OP_START:   cmdBits[CB_START]   = 1'b1;
      OP_RESTART: cmdBits[CB_RESTART] = 1'b1;
      OP_STOP:    cmdBits[CB_STOP]    = 1'b1;
      OP_RX:      cmdBits[CB_RX]      = 1'b1;
      OP_ACK:     cmdBits[CB_ACK]     = 1'b1;
      default:    cmdBits = '0;
    endcase
  end

  assign ctlRdata = {ackStat, ackData, cmdBits};

  // R8: at most one command bit reads as set
  assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctlRdata[CMD_W-1:0]));
  // R11: within byte and acknowledge phases SDA holds while SCL stays released
  assert_sda_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bitOp && !sclOe && $past(!sclOe)) |-> $stable(sdaOe));
  // R12: a command bit is visible only while busy
  assert_cmd_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdata[CMD_W-1:0] != '0) |-> busy);
endmodule

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] divVal = '0;
  logic ctlWe = 1'b0;
  logic [5:0] ctlWdata = '0;
  logic [6:0] ctlRdata;
  logic txWe = 1'b0;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic rxFull, busy, done, sclOe, sdaOe;
  logic sdaIn;

  always #10 clk = ~clk;

  i2c_cmd_master #(.DIV_W(DIV_W)) u_i2c_cmd_master (
    .clk(clk), .rstN(rstN), .divVal(divVal), .ctlWe(ctlWe),
    .ctlWdata(ctlWdata), .ctlRdata(ctlRdata), .txWe(txWe), .txData(txData),
    .rxData(rxData), .rxFull(rxFull), .busy(busy), .done(done),
    .sclOe(sclOe), .sdaOe(sdaOe), .sdaIn(sdaIn)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 0;

  // ---------------- slave model ----------------
  int slaveMode = 0;          // 0 idle, 1 answers a transmitted byte, 2 sends a byte
  logic [7:0] rxPat = 8'h00;
  logic ackBit = 1'b0;
  int highCount = 0;
  logic prevScl = 1'b0;
  logic slaveLine;

  always_comb begin
    slaveLine = 1'b1;
    if (slaveMode == 2 && highCount < 8) slaveLine = rxPat[7 - highCount];
    else if (slaveMode == 1 && highCount == 8) slaveLine = ackBit;
    sdaIn = sdaOe ? 1'b0 : slaveLine;
  end

  always @(posedge clk) begin
    prevScl <= sclOe;
    if (!busy) highCount <= 0;
    else if (sclOe && !prevScl) highCount <= highCount + 1;
  end

  // ---------------- reference model ----------------
  typedef struct {
    bit scl;
    bit sda;
    bit [4:0] cmd;
    int req;
  } step_t;

  step_t expQ[$];
  bit pendingDone = 0;
  int pendCap = 0;            // 1 capture received byte, 2 capture answer
  logic [7:0] mRxData = '0, mCapData = '0;
  bit mRxFull = 0, mAckStat = 0, mAckData = 0, mCapAck = 0;
  bit mScl = 0, mSda = 0;

  function automatic void addStep(bit scl, bit sda, bit [4:0] cmd, int req, int t);
    step_t s;
    s.scl = scl; s.sda = sda; s.cmd = cmd; s.req = req;
    for (int i = 0; i < t; i++) expQ.push_back(s);
  endfunction

  // kind: 0 start,1 restart,2 stop,3 receive,4 acknowledge,5 transmit
  function automatic void buildOp(int kind, logic [7:0] data, bit a, int t);
    case (kind)
      0: begin // R2 start: released/released, SDA low, both low
        addStep(0, 0, 5'b00001, 2, t); addStep(0, 1, 5'b00001, 2, t); addStep(1, 1, 5'b00001, 2, t);
      end
      1: begin // R3 repeated start
        addStep(1, 0, 5'b00010, 3, t); addStep(0, 0, 5'b00010, 3, t);
        addStep(0, 1, 5'b00010, 3, t); addStep(1, 1, 5'b00010, 3, t);
      end
      2: begin // R4 stop
        addStep(1, 1, 5'b00100, 4, t); addStep(0, 1, 5'b00100, 4, t); addStep(0, 0, 5'b00100, 4, t);
      end
      3: begin // R6 receive, SDA released throughout
        for (int b = 0; b < 8; b++) begin
          addStep(1, 0, 5'b01000, 6, t); addStep(0, 0, 5'b01000, 6, t);
        end
        addStep(1, 0, 5'b01000, 6, t);
      end
      4: begin // R7 acknowledge pulse
        addStep(1, ~a, 5'b10000, 7, t); addStep(0, ~a, 5'b10000, 7, t); addStep(1, ~a, 5'b10000, 7, t);
      end
      default: begin // R5 transmit, MSB first, ninth pulse released
        for (int b = 7; b >= 0; b--) begin
          addStep(1, ~data[b], 5'b00000, 5, t); addStep(0, ~data[b], 5'b00000, 5, t);
        end
        addStep(1, 0, 5'b00000, 5, t); addStep(0, 0, 5'b00000, 5, t);
        addStep(1, 0, 5'b00000, 5, t);
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (rstN && running) begin
      automatic bit idleM = (expQ.size() == 0) && !pendingDone;
      automatic bit single = ctlWe && ($countones(ctlWdata[4:0]) == 1);
      automatic int t = int'(divVal) + 1;
      if (idleM && single) begin
        mRxFull = 0;
        pendCap = 0;
        if (ctlWdata[0])      buildOp(0, 8'h00, 0, t);
        else if (ctlWdata[1]) buildOp(1, 8'h00, 0, t);
        else if (ctlWdata[2]) buildOp(2, 8'h00, 0, t);
        else if (ctlWdata[3]) begin buildOp(3, 8'h00, 0, t); pendCap = 1; mCapData = rxPat; end
        else                  buildOp(4, 8'h00, ctlWdata[5], t);
      end else if (idleM && txWe) begin
        mRxFull = 0;
        buildOp(5, txData, 0, t);
        pendCap = 2;
        mCapAck = ackBit;
      end
      if (ctlWe) mAckData = ctlWdata[5];
    end
  end

  task automatic chk(string what, int r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h at cycle %0d", r, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison; R11 phase lengths are implied by the step queue
  always @(negedge clk) begin
    if (rstN && running) begin
      bit eScl, eSda, eBusy, eDone;
      bit [4:0] eCmd;
      int r;
      if (expQ.size() > 0) begin
        step_t s;
        s = expQ.pop_front();
        eScl = s.scl; eSda = s.sda; eCmd = s.cmd; r = s.req;
        eBusy = 1; eDone = 0;
        mScl = s.scl; mSda = s.sda;
        if (expQ.size() == 0) pendingDone = 1;
      end else begin
        eScl = mScl; eSda = mSda; eCmd = '0; r = 11;
        eBusy = 0; eDone = pendingDone;
        if (pendingDone) begin
          if (pendCap == 1) begin mRxData = mCapData; mRxFull = 1; end
          if (pendCap == 2) mAckStat = mCapAck;
          pendCap = 0;
          pendingDone = 0;
        end
      end
      chk("sclOe", r, {7'd0, sclOe}, {7'd0, eScl});
      chk("sdaOe", r, {7'd0, sdaOe}, {7'd0, eSda});
      chk("busy (R12)", 12, {7'd0, busy}, {7'd0, eBusy});
      chk("done (R12)", 12, {7'd0, done}, {7'd0, eDone});
      chk("command bits (R8)", 8, {3'd0, ctlRdata[4:0]}, {3'd0, eCmd});
      chk("ack data (R9)", 9, {7'd0, ctlRdata[5]}, {7'd0, mAckData});
      chk("ack status (R5)", 5, {7'd0, ctlRdata[6]}, {7'd0, mAckStat});
      chk("rxFull (R6)", 6, {7'd0, rxFull}, {7'd0, mRxFull});
      chk("rxData (R6)", 6, rxData, mRxData);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wrCtl(logic [5:0] d);
    @(negedge clk);
    ctlWe = 1'b1; ctlWdata = d;
    @(negedge clk);
    ctlWe = 1'b0; ctlWdata = '0;
  endtask

  task automatic wrTx(logic [7:0] d);
    @(negedge clk);
    txWe = 1'b1; txData = d;
    @(negedge clk);
    txWe = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (expQ.size() != 0 || pendingDone);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("reset control word R1", 1, {1'b0, ctlRdata}, 8'h00);
    chk("reset lines R1", 1, {6'd0, sclOe, sdaOe}, 8'h00);
    chk("reset flags R1", 1, {5'd0, busy, done, rxFull}, 8'h00);
    running = 1;

    divVal = 8'd1;
    wrCtl(6'b000001); waitIdle();                                     // R2
    slaveMode = 1; ackBit = 1'b0; wrTx(8'hA5); waitIdle();            // R5 acknowledged
    chk("ack status after ACK R5", 5, {7'd0, ctlRdata[6]}, 8'h00);
    ackBit = 1'b1; wrTx(8'h3C); waitIdle();                           // R5 not acknowledged
    chk("ack status after NACK R5", 5, {7'd0, ctlRdata[6]}, 8'h01);
    wrCtl(6'b000010); waitIdle();                                     // R3
    slaveMode = 2; rxPat = 8'h96; wrCtl(6'b001000); waitIdle();       // R6
    chk("received byte R6", 6, rxData, 8'h96);
    chk("buffer full R6", 6, {7'd0, rxFull}, 8'h01);
    slaveMode = 0; wrCtl(6'b010000); waitIdle();                      // R7 ACK
    chk("buffer full cleared R6", 6, {7'd0, rxFull}, 8'h00);
    wrCtl(6'b000100); waitIdle();                                     // R4

    divVal = 8'd3;
    wrCtl(6'b000001);
    repeat (2) @(negedge clk);
    chk("start bit visible R8", 8, {3'd0, ctlRdata[4:0]}, 8'h01);
    wrCtl(6'b100100);                                                 // R9 stop refused, ack data taken
    wrTx(8'hFF);                                                      // R9 transmit refused
    waitIdle();
    chk("ack data written while busy R9", 9, {7'd0, ctlRdata[5]}, 8'h01);
    chk("command bits self-cleared R8", 8, {3'd0, ctlRdata[4:0]}, 8'h00);
    wrCtl(6'b000011);                                                 // R10
    repeat (3) @(negedge clk);
    chk("multi-bit command ignored R10", 10, {7'd0, busy}, 8'h00);
    slaveMode = 2; rxPat = 8'h01; wrCtl(6'b001000); waitIdle();
    chk("received byte LSB R6", 6, rxData, 8'h01);
    slaveMode = 0; wrCtl(6'b110000); waitIdle();                      // R7 NACK with new data bit
    wrCtl(6'b000100); waitIdle();

    divVal = 8'd0;                                                    // R11 shortest phases
    wrCtl(6'b000001); waitIdle();
    wrCtl(6'b000100); waitIdle();

    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule